// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the software-visible face of a UART. It sits on a 16-bit register bus and decodes twelve word-spaced registers: two divisor halves for the baud generator, global, line and modem control words, a line status word, a modem status word, a scratch word, two aliases that set and clear interrupt enables, a transmit holding word and a receive buffer word. The serial shifter, baud generator, FIFOs and DMA engine live outside. The block talks to them through strobes, live status inputs and configuration outputs.

Interrupt enables cannot be written directly. One alias ORs bits in and the other clears the bits that are written as one. Error flags reported by the receiver and transmitter are sticky until software writes one to them. The data-ready and transmitter-empty bits of the line status word are not stored: every read takes them from the live inputs. Each bus request gets a registered response one cycle later. A response reports one of three outcomes: success, a wrong access size, or an address that holds no register.

Top module: `uart_csr_block`

## Requirements
- R1: After reset the divisor low output is 0x0001, the divisor high, global, line and modem outputs are 0, and the enables are 0. A line status read with the transmit-room and transmitter-drained inputs high and no receive data returns 0x0060.
- R2: Register index is bus_addr[5:2]. The order is 0 divisor low, 1 divisor high, 2 global, 3 line, 4 modem, 5 line status, 6 modem status, 7 scratch, 8 enable set, 9 enable clear, 10 transmit holding, 11 receive buffer. Writes to indexes 0–4, 7 and 10 store all 16 bits and reads return them. Every request produces rsp_valid in the next cycle, and write responses carry rsp_rdata 0.
- R3: Only bus_size 1 (16 bit) is accepted. Any other size gives rsp_err 1. Otherwise a nonzero bus_addr[1:0] or an index above 11 gives rsp_err 2. Size has priority over the unmapped case. An errored access returns data 0 and changes no state and no strobe.
- R4: A write to index 8 ORs wdata[2:0] into the enables (bit 0 receive, bit 1 transmit, bit 2 line status).
- R5: A write to index 9 clears each enable bit written as one. Reads of index 8 or 9 return the enables in bits 2:0.
- R6: Line status bits 1 overrun, 2 parity, 3 framing, 4 break and 7 transmit-finished are sticky. stat_evt[0..3] sets bits 1..4 and stat_evt[4] sets bit 7. Writing one to these bits at index 5 clears them. A set in the same cycle wins. Other written bits have no effect.
- R7: Line status reads return rxq_nonempty in bit 0, txq_room in bit 5 and tx_drained in bit 6, sampled in the request cycle.
- R8: Modem status bit 0 is a sticky CTS-change flag. It is set by cts_delta and cleared by writing one to bit 0. Bit 4 returns cts_level live. Other written bits have no effect.
- R9: A valid write to index 10 pulses txq_push for one cycle with txq_data = wdata[7:0]. tx_irq_pulse comes with it when enable bit 1 was set. Reads of index 10 return the last written word.
- R10: A read of index 11 with rxq_nonempty high returns rxq_head, stores it and pulses rxq_pop. With rxq_nonempty low it returns the stored byte and does not pop. Writes to index 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_size | input | 2 | Access size code, 1 = 16 bit |
| bus_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 2 | 0 ok, 1 bad size, 2 no register |
| rsp_rdata | output | 16 | Read data |
| stat_evt | input | 5 | Sticky error set pulses |
| cts_level | input | 1 | Live clear-to-send level |
| cts_delta | input | 1 | Clear-to-send change pulse |
| rxq_nonempty | input | 1 | Receive data available |
| rxq_head | input | 8 | Next received byte |
| rxq_pop | output | 1 | Receive byte consumed |
| txq_room | input | 1 | Transmit holding space free |
| tx_drained | input | 1 | Transmitter fully idle |
| txq_push | output | 1 | Transmit byte strobe |
| txq_data | output | 8 | Transmit byte |
| tx_irq_pulse | output | 1 | Transmit event |
| cfg_div_lo | output | 16 | Divisor low word |
| cfg_div_hi | output | 16 | Divisor high word |
| cfg_global | output | 16 | Global control word |
| cfg_line | output | 16 | Line control word |
| cfg_modem | output | 16 | Modem control word |
| cfg_irq_en | output | 3 | Interrupt enables |

## Verification
Most stored state shows up in the response to the next read of its index, one cycle after the request. A corrupted enable or sticky flag therefore appears only when software reads it back, or, for the transmit enable, on the next tx_irq_pulse. Configuration words also drive dedicated outputs, so a wrong value is visible there in the cycle after the write. The bench reads every register back often under random traffic. It also checks each strobe in the response cycle, so a wrong state normally surfaces within a few accesses.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int NUM_REGS = 12;
  localparam int IEN_W    = 3;
  localparam int LS_W     = 8;
  localparam int EVT_W    = 5;

  typedef enum logic [3:0] {
    IDX_DIVLO   = 4'd0,
    IDX_DIVHI   = 4'd1,
    IDX_GLOBAL  = 4'd2,
    IDX_LINE    = 4'd3,
    IDX_MODEM   = 4'd4,
    IDX_LSTAT   = 4'd5,
    IDX_MSTAT   = 4'd6,
    IDX_SCRATCH = 4'd7,
    IDX_IEN_SET = 4'd8,
    IDX_IEN_CLR = 4'd9,
    IDX_TXHOLD  = 4'd10,
    IDX_RXBUF   = 4'd11
  } reg_idx_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SIZE  = 2'd1,
    ERR_NOREG = 2'd2
  } rsp_err_e;

  localparam logic [1:0] SIZE_HALF = 2'd1;

  // line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_PE   = 2;
  localparam int LS_FE   = 3;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LS_TFI  = 7;
  localparam logic [LS_W-1:0] STICKY_MASK = 8'h9E;

  // modem status bit positions
  localparam int MS_DELTA = 0;
  localparam int MS_LEVEL = 4;

  // enable bit positions
  localparam int IE_RX   = 0;
  localparam int IE_TX   = 1;
  localparam int IE_LINE = 2;

  // registers that simply store the written word
  localparam logic [NUM_REGS-1:0] PLAIN_MASK = 12'b0100_1001_1111;
endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                bus_req,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  output logic [NUM_REGS-1:0] hit,
  output rsp_err_e            err_code
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] idx;
  logic             size_ok;
  logic             mapped;
  logic             ok;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign size_ok = (bus_size == SIZE_HALF);
  assign mapped  = (bus_addr[1:0] == 2'b00) && (idx <= LAST_IDX);
  assign ok      = bus_req && size_ok && mapped;

  always_comb begin
    if (!bus_req)      err_code = ERR_NONE;
    else if (!size_ok) err_code = ERR_SIZE;
    else if (!mapped)  err_code = ERR_NOREG;
    else               err_code = ERR_NONE;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = ok && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/uart_csr_regfile.sv
module uart_csr_regfile
  import uart_csr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] wr_hit,
  input  logic [NUM_REGS-1:0] rd_hit,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [EVT_W-1:0]    stat_evt,
  input  logic                cts_delta,
  input  logic                rxq_nonempty,
  input  logic [BYTE_W-1:0]   rxq_head,
  output logic [DATA_W-1:0]   plain_q [NUM_REGS],
  output logic [IEN_W-1:0]    ien_q,
  output logic [LS_W-1:0]     sticky_q,
  output logic                scts_q,
  output logic [DATA_W-1:0]   rbr_q,
  output logic                txq_push,
  output logic [BYTE_W-1:0]   txq_data,
  output logic                tx_irq_pulse,
  output logic                rxq_pop
);
  // plain storage words, one generated slot per index
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_plain
    if (PLAIN_MASK[i]) begin : g_store
      localparam logic [DATA_W-1:0] RST_V = (i == 0) ? DATA_W'(1) : '0;
      always_ff @(posedge clk) begin
        if (rst)            plain_q[i] <= RST_V;
        else if (wr_hit[i]) plain_q[i] <= wdata;
      end
    end else begin : g_none
      assign plain_q[i] = '0;
    end
  end

  // sticky error flags: set beats write-one-to-clear
  logic [LS_W-1:0] set_v;
  logic [LS_W-1:0] clr_v;
  always_comb begin
    set_v         = '0;
    set_v[LS_OE]  = stat_evt[0];
    set_v[LS_PE]  = stat_evt[1];
    set_v[LS_FE]  = stat_evt[2];
    set_v[LS_BI]  = stat_evt[3];
    set_v[LS_TFI] = stat_evt[4];
    clr_v = wr_hit[IDX_LSTAT] ? (wdata[LS_W-1:0] & STICKY_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) sticky_q <= '0;
    else     sticky_q <= (sticky_q & ~clr_v) | set_v;
  end

  // interrupt enables reachable only through the two aliases
  always_ff @(posedge clk) begin
    if (rst)                      ien_q <= '0;
    else if (wr_hit[IDX_IEN_SET]) ien_q <= ien_q | wdata[IEN_W-1:0];
    else if (wr_hit[IDX_IEN_CLR]) ien_q <= ien_q & ~wdata[IEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) scts_q <= 1'b0;
    else     scts_q <= (scts_q & ~(wr_hit[IDX_MSTAT] & wdata[MS_DELTA])) | cts_delta;
  end

  // receive buffer keeps the last byte fetched
  always_ff @(posedge clk) begin
    if (rst)                                   rbr_q <= '0;
    else if (rd_hit[IDX_RXBUF] && rxq_nonempty) rbr_q <= DATA_W'(rxq_head);
  end

  // strobes toward the transmit and receive paths
  always_ff @(posedge clk) begin
    if (rst) begin
      txq_push     <= 1'b0;
      txq_data     <= '0;
      tx_irq_pulse <= 1'b0;
      rxq_pop      <= 1'b0;
    end else begin
      txq_push     <= wr_hit[IDX_TXHOLD];
      tx_irq_pulse <= wr_hit[IDX_TXHOLD] & ien_q[IE_TX];
      rxq_pop      <= rd_hit[IDX_RXBUF] & rxq_nonempty;
      if (wr_hit[IDX_TXHOLD]) txq_data <= wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/uart_csr_rdmux.sv
module uart_csr_rdmux
  import uart_csr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  rsp_err_e            err_code,
  input  logic [NUM_REGS-1:0] rd_hit,
  input  logic [DATA_W-1:0]   view [NUM_REGS],
  output logic                rsp_valid,
  output logic [1:0]          rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata
);
  logic [DATA_W-1:0] sel_data;

  // one-hot AND-OR selection, zero when nothing is read
  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      sel_data = sel_data | (view[i] & {DATA_W{rd_hit[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= ERR_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_req;
      rsp_err   <= err_code;
      rsp_rdata <= sel_data;
    end
  end
endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [EVT_W-1:0]   stat_evt,
  input  logic               cts_level,
  input  logic               cts_delta,
  input  logic               rxq_nonempty,
  input  logic [BYTE_W-1:0]  rxq_head,
  output logic               rxq_pop,
  input  logic               txq_room,
  input  logic               tx_drained,
  output logic               txq_push,
  output logic [BYTE_W-1:0]  txq_data,
  output logic               tx_irq_pulse,
  output logic [DATA_W-1:0]  cfg_div_lo,
  output logic [DATA_W-1:0]  cfg_div_hi,
  output logic [DATA_W-1:0]  cfg_global,
  output logic [DATA_W-1:0]  cfg_line,
  output logic [DATA_W-1:0]  cfg_modem,
  output logic [IEN_W-1:0]   cfg_irq_en
);
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;
  rsp_err_e            err_code;

  logic [DATA_W-1:0]   plain_q [NUM_REGS];
  logic [DATA_W-1:0]   view    [NUM_REGS];
  logic [IEN_W-1:0]    ien_q;
  logic [LS_W-1:0]     sticky_q;
  logic                scts_q;
  logic [DATA_W-1:0]   rbr_q;
  logic [LS_W-1:0]     lstat;
  logic [LS_W-1:0]     mstat;

  uart_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .hit      (hit),
    .err_code (err_code)
  );

  assign wr_hit = hit & {NUM_REGS{bus_we}};
  assign rd_hit = hit & {NUM_REGS{~bus_we}};

  uart_csr_regfile #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_hit       (wr_hit),
    .rd_hit       (rd_hit),
    .wdata        (bus_wdata),
    .stat_evt     (stat_evt),
    .cts_delta    (cts_delta),
    .rxq_nonempty (rxq_nonempty),
    .rxq_head     (rxq_head),
    .plain_q      (plain_q),
    .ien_q        (ien_q),
    .sticky_q     (sticky_q),
    .scts_q       (scts_q),
    .rbr_q        (rbr_q),
    .txq_push     (txq_push),
    .txq_data     (txq_data),
    .tx_irq_pulse (tx_irq_pulse),
    .rxq_pop      (rxq_pop)
  );

  // live status folded over the sticky flags
  always_comb begin
    lstat          = sticky_q & STICKY_MASK;
    lstat[LS_DR]   = rxq_nonempty;
    lstat[LS_THRE] = txq_room;
    lstat[LS_TEMT] = tx_drained;
    mstat           = '0;
    mstat[MS_DELTA] = scts_q;
    mstat[MS_LEVEL] = cts_level;
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) view[i] = plain_q[i];
    view[IDX_LSTAT]   = DATA_W'(lstat);
    view[IDX_MSTAT]   = DATA_W'(mstat);
    view[IDX_IEN_SET] = DATA_W'(ien_q);
    view[IDX_IEN_CLR] = DATA_W'(ien_q);
    view[IDX_RXBUF]   = rxq_nonempty ? DATA_W'(rxq_head) : rbr_q;
  end

  uart_csr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .err_code  (err_code),
    .rd_hit    (rd_hit),
    .view      (view),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  assign cfg_div_lo = plain_q[IDX_DIVLO];
  assign cfg_div_hi = plain_q[IDX_DIVHI];
  assign cfg_global = plain_q[IDX_GLOBAL];
  assign cfg_line   = plain_q[IDX_LINE];
  assign cfg_modem  = plain_q[IDX_MODEM];
  assign cfg_irq_en = ien_q;
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_valid,
  input logic [1:0]        rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rxq_nonempty,
  input logic              rxq_pop,
  input logic              txq_push,
  input logic              tx_irq_pulse,
  input logic [2:0]        cfg_irq_en
);
  logic good_wr;
  logic set_wr;
  logic clr_wr;
  assign good_wr = bus_req && bus_we && (bus_size == 2'd1) && (bus_addr[1:0] == 2'b00);
  assign set_wr  = good_wr && (bus_addr == ADDR_W'(8 * 4));
  assign clr_wr  = good_wr && (bus_addr == ADDR_W'(9 * 4));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> rsp_valid);
  // R2
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !rsp_valid);
  // R3
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err != 2'd0) |-> (rsp_rdata == '0));
  // R3
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err != 2'd0) |-> (!txq_push && !rxq_pop));
  // R4
  ien_set_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((cfg_irq_en & $past(cfg_irq_en)) == $past(cfg_irq_en)));
  // R5
  ien_clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((cfg_irq_en & $past(bus_wdata[2:0])) == 3'b000));
  // R9
  tx_event_with_push_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq_pulse |-> txq_push);
  // R10
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    rxq_pop |-> $past(rxq_nonempty));
endmodule

bind uart_csr_block uart_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .bus_wdata    (bus_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_rdata    (rsp_rdata),
  .rxq_nonempty (rxq_nonempty),
  .rxq_pop      (rxq_pop),
  .txq_push     (txq_push),
  .tx_irq_pulse (tx_irq_pulse),
  .cfg_irq_en   (cfg_irq_en)
);

// File: tb/uart_csr_block_test.sv
module uart_csr_block_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [5:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [15:0] bus_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_err;
  logic [15:0] rsp_rdata;
  logic [4:0]  stat_evt;
  logic        cts_level, cts_delta, rxq_nonempty, txq_room, tx_drained;
  logic [7:0]  rxq_head;
  logic        rxq_pop, txq_push, tx_irq_pulse;
  logic [7:0]  txq_data;
  logic [15:0] cfg_div_lo, cfg_div_hi, cfg_global, cfg_line, cfg_modem;
  logic [2:0]  cfg_irq_en;

  always #2 clk = ~clk;

  uart_csr_block uut (.*);

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model
  logic [15:0] m_reg [12];
  logic [2:0]  m_ien;
  logic [7:0]  m_sticky;
  logic        m_scts;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_err(input logic [5:0] a, input logic [1:0] s);
    if (s != 2'd1) return 2'd1;
    if (a[1:0] != 2'b00 || a[5:2] > 4'd11) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [3:0] idx);
    case (idx)
      4'd5:      return {8'h00, m_sticky | {1'b0, tx_drained, txq_room, 4'b0000, rxq_nonempty}};
      4'd6:      return {11'd0, cts_level, 3'b000, m_scts};
      4'd8, 4'd9: return {13'd0, m_ien};
      4'd11:     return rxq_nonempty ? {8'h00, rxq_head} : m_reg[11];
      default:   return m_reg[idx];
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 12; i++) m_reg[i] = 16'h0;
    m_reg[0] = 16'h0001;
    m_ien = 3'b000; m_sticky = 8'h00; m_scts = 1'b0;
  endtask

  // one access; live inputs must already be set by the caller
  task automatic op(input logic we, input logic [5:0] a, input logic [1:0] sz,
                    input logic [15:0] wd, input logic [4:0] ev, input logic cd);
    logic [1:0]  e_err;
    logic [3:0]  idx;
    logic [15:0] e_data;
    logic        e_push, e_irq, e_pop, ok;
    logic [7:0]  setv, clrv;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    stat_evt = ev; cts_delta = cd;
    e_err  = exp_err(a, sz);
    ok     = (e_err == 2'd0);
    idx    = a[5:2];
    e_data = (ok && !we) ? exp_rd(idx) : 16'h0;
    e_push = ok && we && idx == 4'd10;
    e_irq  = e_push && m_ien[1];
    e_pop  = ok && !we && idx == 4'd11 && rxq_nonempty;
    // model update
    if (ok && !we && idx == 4'd11 && rxq_nonempty) m_reg[11] = {8'h00, rxq_head};
    if (ok && we) begin
      case (idx)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd10: m_reg[idx] = wd;
        4'd8: m_ien = m_ien | wd[2:0];
        4'd9: m_ien = m_ien & ~wd[2:0];
        default: ;
      endcase
    end
    setv = {ev[4], 2'b00, ev[3:0], 1'b0};
    clrv = (ok && we && idx == 4'd5) ? (wd[7:0] & 8'h9E) : 8'h00;
    m_sticky = (m_sticky & ~clrv) | setv;
    m_scts = (m_scts & ~(ok && we && idx == 4'd6 && wd[0])) | cd;
    @(negedge clk);
    chk("R2 rsp_valid", rsp_valid, 1'b1);
    chk("R3 rsp_err", rsp_err, e_err);
    chk("R2/R7/R10 rdata", rsp_rdata, e_data);
    chk("R9 txq_push", txq_push, e_push);
    if (e_push) chk("R9 txq_data", txq_data, wd[7:0]);
    chk("R9 tx_irq_pulse", tx_irq_pulse, e_irq);
    chk("R10 rxq_pop", rxq_pop, e_pop);
    chk("R2 cfg_div_lo", cfg_div_lo, m_reg[0]);
    chk("R2 cfg_line", cfg_line, m_reg[3]);
    chk("R4 cfg_irq_en", cfg_irq_en, m_ien);
    bus_req = 1'b0; stat_evt = 5'd0; cts_delta = 1'b0;
  endtask

  task automatic idle();
    bus_req = 1'b0;
    @(negedge clk);
    chk("R2 no rsp when idle", rsp_valid, 1'b0);
    chk("R9 no push when idle", txq_push, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = 2'd1;
    bus_wdata = '0; stat_evt = '0; cts_level = 1'b0; cts_delta = 1'b0;
    rxq_nonempty = 1'b0; rxq_head = '0; txq_room = 1'b1; tx_drained = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 div_lo", cfg_div_lo, 16'h0001);
    chk("R1 div_hi", cfg_div_hi, 16'h0000);
    chk("R1 global", cfg_global, 16'h0000);
    chk("R1 modem", cfg_modem, 16'h0000);
    chk("R1 irq_en", cfg_irq_en, 3'b000);
    op(1'b0, 6'h14, 2'd1, 16'h0, 5'd0, 1'b0);
    chk("R1 line status after reset", rsp_rdata, 16'h0060);
    idle();

    // R3 size beats unmapped; bad writes change nothing
    op(1'b1, 6'h31, 2'd2, 16'hFFFF, 5'd0, 1'b0);
    chk("R3 size priority", rsp_err, 2'd1);
    op(1'b1, 6'h02, 2'd1, 16'hBEEF, 5'd0, 1'b0);
    chk("R3 misaligned no store", cfg_div_lo, 16'h0001);
    op(1'b1, 6'h20, 2'd0, 16'h0007, 5'd0, 1'b0);
    chk("R3 byte-size set no effect", cfg_irq_en, 3'b000);

    // R9 transmit without and with enable
    op(1'b1, 6'h28, 2'd1, 16'h12A5, 5'd0, 1'b0);
    op(1'b1, 6'h20, 2'd1, 16'h0002, 5'd0, 1'b0);
    op(1'b1, 6'h28, 2'd1, 16'h005A, 5'd0, 1'b0);
    chk("R9 event with enable", tx_irq_pulse, 1'b1);
    op(1'b0, 6'h24, 2'd1, 16'h0, 5'd0, 1'b0);
    op(1'b1, 6'h24, 2'd1, 16'h0002, 5'd0, 1'b0);
    chk("R5 clear aliased", cfg_irq_en, 3'b000);

    // R6 set beats clear in the same cycle
    op(1'b0, 6'h10, 2'd1, 16'h0, 5'b11111, 1'b0);
    op(1'b1, 6'h14, 2'd1, 16'h00FF, 5'b00001, 1'b0);
    op(1'b0, 6'h14, 2'd1, 16'h0, 5'd0, 1'b0);
    chk("R6 overrun kept after clash", rsp_rdata[1], 1'b1);
    chk("R6 framing cleared", rsp_rdata[3], 1'b0);

    // R8 change flag
    cts_level = 1'b1;
    op(1'b0, 6'h18, 2'd1, 16'h0, 5'd0, 1'b1);
    op(1'b0, 6'h18, 2'd1, 16'h0, 5'd0, 1'b0);
    chk("R8 level and delta", rsp_rdata, 16'h0011);
    op(1'b1, 6'h18, 2'd1, 16'hFFFF, 5'd0, 1'b0);

    // R10 receive empty and full, write ignored
    rxq_nonempty = 1'b1; rxq_head = 8'hC3;
    op(1'b0, 6'h2C, 2'd1, 16'h0, 5'd0, 1'b0);
    rxq_nonempty = 1'b0; rxq_head = 8'h11;
    op(1'b1, 6'h2C, 2'd1, 16'h7777, 5'd0, 1'b0);
    op(1'b0, 6'h2C, 2'd1, 16'h0, 5'd0, 1'b0);
    chk("R10 held byte", rsp_rdata, 16'h00C3);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [5:0]  a;
      logic [1:0]  sz;
      logic [4:0]  ev;
      int r;
      r = $urandom_range(0, 99);
      if (r < 5) begin idle(); continue; end
      a  = {$urandom_range(0, 11)}[3:0] << 2;
      if (r < 10) a = 6'($urandom_range(0, 63));
      sz = (r >= 10 && r < 14) ? 2'($urandom_range(0, 3)) : 2'd1;
      ev = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'd0;
      cts_level    = 1'($urandom);
      rxq_nonempty = 1'($urandom);
      rxq_head     = 8'($urandom);
      txq_room     = 1'($urandom);
      tx_drained   = 1'($urandom);
      op(1'($urandom), a, sz, 16'($urandom), ev, ($urandom_range(0, 7) == 0));
    end

    // R1/R2 read back every register at the end
    for (int i = 0; i < 12; i++) op(1'b0, 6'(i * 4), 2'd1, 16'h0, 5'd0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule